// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block takes a group of external pins that share a single interrupt line and turns them into one request for the interrupt sequencer. Each pin is first brought into the clock domain by a synchroniser. A per-pin enable mask then selects which pins take part. The selected pins are combined with an AND onto one active-low line, so a low level on any selected pin pulls the combined line low. Pins that are not selected count as high.

A two-bit sensitivity field applies to the combined line as a whole, not to each pin. In level mode the request follows the combined line, and nothing is stored. In the three edge modes a detected transition sets a pending latch. The latch stays set until the sequencer pulses an acknowledge on entry to the service routine, so the request is kept while the core has interrupts masked.

In rising-edge mode, a low level on any selected pin blocks the request output for as long as it lasts. The pending latch is kept during that time. The same request also drives a wake-up output that lets the core leave Halt.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, with all pins high, `irq_o` and `wake_o` are 0.
- R2: Only pins whose `pin_en_i` bit is 1 take part. The combined line is low when any selected pin is low. Unselected pins have no effect, and with no pin selected no request is ever raised.
- R3: With `sense_i` = 2'b00 (low level), `irq_o` is 1 exactly while the combined line is low, 3 cycles after a pin change. Nothing is latched, and `ack_i` has no effect.
- R4: With `sense_i` = 2'b10 (falling edge), a high-to-low transition of the combined line sets the pending latch. `irq_o` rises 4 cycles after the pin change.
- R5: With `sense_i` = 2'b01 (rising edge), a low-to-high transition of the combined line sets the latch. A high-to-low transition sets nothing.
- R6: With `sense_i` = 2'b11 (both edges), either transition of the combined line sets the latch.
- R7: In the edge modes, a set latch keeps `irq_o` high after the pins return to their idle level.
- R8: A one-cycle `ack_i` clears the latch at that clock edge. If a new edge is detected in the same cycle, the latch stays set.
- R9: With `sense_i` = 2'b01, `irq_o` is 0 while any selected pin is low, even with the latch set.
- R10: `wake_o` always equals `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw external pins, asynchronous |
| pin_en_i | input | NUM_PINS | Per-pin selection mask |
| sense_i | input | 2 | Sensitivity: 00 low level, 01 rising, 10 falling, 11 both edges |
| ack_i | input | 1 | One-cycle pulse on service-routine entry |
| irq_o | output | 1 | Request to the interrupt sequencer |
| wake_o | output | 1 | Halt wake-up request |

## Verification
A pin change passes through two synchroniser flops and then the combined-line register. The level request is therefore due 3 clock edges after the change, and an edge request needs one more edge to reach the latch, which makes it due after 4. The bench drives inputs on the falling clock edge and waits 5 rising edges before it samples each vector result, which covers both paths. Acknowledge checks are sampled at the falling edge right after the single rising edge that carries the pulse. The same-cycle case places the acknowledge on exactly the 4th rising edge after the pin change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i[p]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end

      assign sync_o[p] = chain_q[LAST];
    end
  endgenerate
endmodule

// File: rtl/ext_irq_combine.sv
module ext_irq_combine #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             line_o
);
  logic line_d;
  logic line_q;

  always_comb begin
    line_d = &(sync_i | ~en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_d;
  end

  assign line_o = line_q;

  // R2
  low_pulls_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~sync_i & en_i)) |=> !line_o);

  // R2
  none_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> line_o);
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_i,
  input  sense_e sense_i,
  input  logic   ack_i,
  output logic   irq_o
);
  logic prev_q;
  logic pend_q, pend_d;
  logic rise, fall, hit;

  always_comb begin
    rise = line_i & ~prev_q;
    fall = ~line_i & prev_q;
    unique case (sense_i)
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase

    if (sense_i == SENSE_LOW) pend_d = 1'b0;
    else if (hit)             pend_d = 1'b1;
    else if (ack_i)           pend_d = 1'b0;
    else                      pend_d = pend_q;

    if (sense_i == SENSE_LOW)       irq_o = ~line_i;
    else if (sense_i == SENSE_RISE) irq_o = pend_q & line_i;
    else                            irq_o = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit) |=> !pend_q);

  // R8
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);

  // R3
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_LOW) |=> !pend_q);

  // R9
  rise_low_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i == SENSE_RISE && !line_i) |-> !irq_o);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic [1:0]          sense_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic                wake_o
);
  logic [1:0]          rst_q;
  logic                rst_int_n;
  logic [NUM_PINS-1:0] pins_sync;
  logic                line;
  sense_e              sense;
  logic                req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign sense = sense_e'(sense_i);

  ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (pins_i),
    .sync_o  (pins_sync)
  );

  ext_irq_combine #(.WIDTH(NUM_PINS)) u_comb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sync_i (pins_sync),
    .en_i   (pin_en_i),
    .line_o (line)
  );

  ext_irq_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .line_i  (line),
    .sense_i (sense),
    .ack_i   (ack_i),
    .irq_o   (req)
  );

  assign irq_o  = req;
  assign wake_o = req;

  // R10
  wake_match_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    wake_o == irq_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_int_n) |-> !irq_o);
endmodule

// File: tb/tb_ext_irq_cond.sv
module tb_ext_irq_cond;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pins;
  logic [N-1:0] en;
  logic [1:0]   sense;
  logic         ack;
  logic         irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {sense, en, base, next, expected}
  typedef struct packed {
    logic [1:0]   s;
    logic [N-1:0] e;
    logic [N-1:0] b;
    logic [N-1:0] n;
    logic         x;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'b00, 4'hF, 4'hF, 4'hE, 1'b1},  // R3 R2
    '{2'b00, 4'hE, 4'hF, 4'hE, 1'b0},  // R2 unselected
    '{2'b00, 4'hF, 4'hF, 4'hF, 1'b0},  // R3
    '{2'b10, 4'h3, 4'hF, 4'hD, 1'b1},  // R4
    '{2'b10, 4'h3, 4'hD, 4'hF, 1'b0},  // R4 rise ignored
    '{2'b01, 4'h3, 4'hD, 4'hF, 1'b1},  // R5
    '{2'b01, 4'h3, 4'hF, 4'hD, 1'b0},  // R5 fall ignored
    '{2'b01, 4'h3, 4'hC, 4'hE, 1'b0},  // R9 still low
    '{2'b11, 4'h3, 4'hF, 4'hE, 1'b1},  // R6 fall
    '{2'b11, 4'h3, 4'hE, 4'hF, 1'b1},  // R6 rise
    '{2'b11, 4'h0, 4'hF, 4'h0, 1'b0},  // R2 none selected
    '{2'b00, 4'h8, 4'hF, 4'h7, 1'b1}   // R2 R3 top pin
  };

  ext_irq_cond #(.NUM_PINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .pin_en_i(en),
    .sense_i(sense), .ack_i(ack), .irq_o(irq), .wake_o(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
    if (wake !== irq) begin
      fails++;
      $display("FAIL R10 wake actual=%b expected=%b", wake, irq);
    end
  endtask

  task automatic clean_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '1; en = '1; sense = 2'b10; ack = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      sense = VECS[i].s; en = VECS[i].e; pins = VECS[i].b;
      step(6);
      clean_ack();
      pins = VECS[i].n;
      step(5);
      chk($sformatf("vector %0d", i), VECS[i].x);
    end

    // R4 / R7: latch holds after pins return
    sense = 2'b10; en = 4'h1; pins = 4'hF;
    step(6); clean_ack();
    pins = 4'hE; step(5);
    chk("R4", 1'b1);
    pins = 4'hF; step(5);
    chk("R7", 1'b1);

    // R8: ack clears
    clean_ack();
    chk("R8 clear", 1'b0);

    // R8: edge in same cycle as ack wins
    pins = 4'hE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R8 same-cycle", 1'b1);
    clean_ack();

    // R3: level mode ignores ack and does not latch
    sense = 2'b00; pins = 4'hE; step(5);
    clean_ack();
    chk("R3 ack ignored", 1'b1);
    pins = 4'hF; step(4);
    chk("R3 no latch", 1'b0);

    // R5 / R9: rising mode, low masks pending request
    sense = 2'b01; en = 4'h3; pins = 4'hC;
    step(6); clean_ack();
    pins = 4'hF; step(5);
    chk("R5", 1'b1);
    pins = 4'hE; step(4);
    chk("R9", 1'b0);
    pins = 4'hF; step(5);
    chk("R5 again", 1'b1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule